// File: doc/BRIEF.md
# Codec Serial Data Shifter

This block is the data path of a full-duplex codec audio port. On each frame it sends one parallel word, bit by bit, on a transmit line. It also collects the same number of bits from a receive line into a parallel word. A bit clock and a frame sync come in from outside. The block oversamples both with the faster system clock, brings them into that domain and finds their edges. Nothing is assumed about how the two are generated.

Three static configuration inputs set the behaviour. The first picks which bit-clock edge launches transmit bits; receive bits are always taken on the other edge. The second picks whether words travel most-significant or least-significant bit first. The third picks the active level of the frame sync. A one-word holding register sits behind a valid/ready handshake and feeds the transmitter. Received words leave on a one-cycle valid strobe. Separate enables gate transmit and receive. If a frame begins while no word is waiting, an underrun flag pulses and the line stays low for that frame.

Top module: `codec_shifter`

## Requirements
- R1: With `cfg_clk_pol`=0 transmit bits are launched on rising bit-clock edges; with 1 on falling edges. The first bit of a word is launched on the first launch edge after the frame sync becomes active.
- R2: Receive bits are sampled on the edge opposite the launch edge: falling when `cfg_clk_pol`=0, rising when 1. One word is collected after each frame start.
- R3: With `cfg_lsb_first`=0 bit W-1 is sent first and the first received bit lands in `rx_data[W-1]`. With 1, bit 0 is sent first and the first received bit lands in `rx_data[0]`.
- R4: `txd_out` is 0 whenever `tx_en` is 0. It is also 0 once the W bits of a word have gone out, from the next launch edge on.
- R5: The frame sync is active low when `cfg_sync_pol`=0 and active high when 1. A frame starts only on a transition into the active level.
- R6: If `tx_en` is 1 and the holding register is empty at frame start, `tx_underrun` pulses for one system clock and `txd_out` stays 0 for that frame.
- R7: `rx_valid` is a single-cycle pulse, given after the W-th bit of a word is sampled. It is not given for frames that start while `rx_en` is 0.
- R8: `tx_ready` is 1 exactly when the holding register is empty. A word is accepted when `tx_valid` and `tx_ready` are both 1. The word stays held, with no underrun, through frames that start while `tx_en` is 0.
- R9: After reset `txd_out`, `rx_valid` and `tx_underrun` are 0 and `tx_ready` is 1. Configuration inputs change only while `rst` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the bit clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_clk_pol | input | 1 | Launch edge select (0 rising, 1 falling) |
| cfg_lsb_first | input | 1 | Bit order select (0 MSB first, 1 LSB first) |
| cfg_sync_pol | input | 1 | Frame sync active level |
| tx_en | input | 1 | Transmit enable |
| rx_en | input | 1 | Receive enable |
| bclk_in | input | 1 | External bit clock |
| fsync_in | input | 1 | External frame sync |
| rxd_in | input | 1 | Serial receive data |
| tx_data | input | WORD_W | Word to transmit |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Holding register empty |
| txd_out | output | 1 | Serial transmit data |
| rx_data | output | WORD_W | Last received word |
| rx_valid | output | 1 | Received word strobe |
| tx_underrun | output | 1 | No word available at frame start |

## Verification
An edge on the bit clock reaches `txd_out` about three system clocks later: two synchroniser stages, then the output register. `rx_valid` and `tx_underrun` follow their triggering bit-clock edge with the same delay. The bench drives the bit clock at 16 system clocks per bit. It reads each transmitted bit 10 clocks after its launch edge, on the falling system-clock edge, well clear of both transitions. Received words are checked by a monitor as they come, against a queue filled when the words were sent. Underrun pulses are counted and compared once the frame has ended.

// File: rtl/codec_shifter_pkg.sv
package codec_shifter_pkg;
  typedef enum logic [1:0] {
    CH_BCLK  = 2'd0,
    CH_FSYNC = 2'd1,
    CH_RXD   = 2'd2
  } sync_ch_e;
  localparam int NUM_CH = 3;
endpackage

// File: rtl/codec_sync.sv
module codec_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic level
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[STAGES-2:0], din};
  end

  assign level = chain_q[STAGES-1];
endmodule

// File: rtl/codec_tx.sv
module codec_tx #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         lsb_first,
  input  logic         go,
  input  logic         shift_ev,
  input  logic [W-1:0] wr_data,
  input  logic         wr_valid,
  output logic         wr_ready,
  output logic         txd,
  output logic         underrun
);
  localparam int CNT_W = $clog2(W + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(W);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic [W-1:0]     hold_q, sreg_q, nxt;
  logic             full_q, busy_q, txd_q, under_q;
  logic [CNT_W-1:0] cnt_q;
  logic             accept, first_bit, nxt_bit;

  assign accept    = wr_valid & ~full_q;
  assign nxt       = lsb_first ? {1'b0, sreg_q[W-1:1]} : {sreg_q[W-2:0], 1'b0};
  assign nxt_bit   = lsb_first ? nxt[0] : nxt[W-1];
  assign first_bit = lsb_first ? hold_q[0] : hold_q[W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q  <= '0;
      sreg_q  <= '0;
      full_q  <= 1'b0;
      busy_q  <= 1'b0;
      txd_q   <= 1'b0;
      under_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      under_q <= 1'b0;
      if (accept) begin
        hold_q <= wr_data;
        full_q <= 1'b1;
      end
      if (go) begin
        if (en && full_q) begin
          sreg_q <= hold_q;
          busy_q <= 1'b1;
          cnt_q  <= CNT_LOAD;
          full_q <= 1'b0;
          txd_q  <= first_bit;
        end else begin
          busy_q  <= 1'b0;
          txd_q   <= 1'b0;
          under_q <= en;
        end
      end else if (shift_ev && busy_q) begin
        if (cnt_q == CNT_ONE) begin
          busy_q <= 1'b0;
          txd_q  <= 1'b0;
        end else begin
          sreg_q <= nxt;
          cnt_q  <= cnt_q - CNT_ONE;
          txd_q  <= en & nxt_bit;
        end
      end else if (!en) begin
        txd_q <= 1'b0;
      end
    end
  end

  assign wr_ready = ~full_q;
  assign txd      = txd_q;
  assign underrun = under_q;
endmodule

// File: rtl/codec_rx.sv
module codec_rx #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         lsb_first,
  input  logic         go,
  input  logic         samp_ev,
  input  logic         rxd,
  output logic [W-1:0] data,
  output logic         valid
);
  localparam int CNT_W = $clog2(W + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(W);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic [W-1:0]     sreg_q, data_q, nxt;
  logic             busy_q, valid_q;
  logic [CNT_W-1:0] cnt_q;

  assign nxt = lsb_first ? {rxd, sreg_q[W-1:1]} : {sreg_q[W-2:0], rxd};

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg_q  <= '0;
      data_q  <= '0;
      busy_q  <= 1'b0;
      valid_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      valid_q <= 1'b0;
      if (go) begin
        busy_q <= en;
        cnt_q  <= CNT_LOAD;
      end else if (samp_ev && busy_q) begin
        sreg_q <= nxt;
        cnt_q  <= cnt_q - CNT_ONE;
        if (cnt_q == CNT_ONE) begin
          busy_q  <= 1'b0;
          data_q  <= nxt;
          valid_q <= 1'b1;
        end
      end
    end
  end

  assign data  = data_q;
  assign valid = valid_q;
endmodule

// File: rtl/codec_shifter.sv
module codec_shifter
  import codec_shifter_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_clk_pol,
  input  logic              cfg_lsb_first,
  input  logic              cfg_sync_pol,
  input  logic              tx_en,
  input  logic              rx_en,
  input  logic              bclk_in,
  input  logic              fsync_in,
  input  logic              rxd_in,
  input  logic [WORD_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic              txd_out,
  output logic [WORD_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              tx_underrun
);
  logic [NUM_CH-1:0] raw, lvl;
  logic bclk_q, fs_act_q, armed_q;
  logic bclk_rise, bclk_fall, shift_ev, samp_ev, fs_act, frame_start, go;

  assign raw[CH_BCLK]  = bclk_in;
  assign raw[CH_FSYNC] = fsync_in;
  assign raw[CH_RXD]   = rxd_in;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_sync
    codec_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst  (rst),
      .din  (raw[g]),
      .level(lvl[g])
    );
  end

  assign bclk_rise   = lvl[CH_BCLK] & ~bclk_q;
  assign bclk_fall   = ~lvl[CH_BCLK] & bclk_q;
  assign shift_ev    = cfg_clk_pol ? bclk_fall : bclk_rise;
  assign samp_ev     = cfg_clk_pol ? bclk_rise : bclk_fall;
  assign fs_act      = lvl[CH_FSYNC] ~^ cfg_sync_pol;
  assign frame_start = fs_act & ~fs_act_q;
  assign go          = armed_q & shift_ev;

  always_ff @(posedge clk) begin
    if (rst) begin
      bclk_q   <= 1'b0;
      fs_act_q <= 1'b1;
      armed_q  <= 1'b0;
    end else begin
      bclk_q   <= lvl[CH_BCLK];
      fs_act_q <= fs_act;
      if (frame_start)   armed_q <= 1'b1;
      else if (shift_ev) armed_q <= 1'b0;
    end
  end

  codec_tx #(.W(WORD_W)) u_tx (
    .clk      (clk),
    .rst      (rst),
    .en       (tx_en),
    .lsb_first(cfg_lsb_first),
    .go       (go),
    .shift_ev (shift_ev),
    .wr_data  (tx_data),
    .wr_valid (tx_valid),
    .wr_ready (tx_ready),
    .txd      (txd_out),
    .underrun (tx_underrun)
  );

  codec_rx #(.W(WORD_W)) u_rx (
    .clk      (clk),
    .rst      (rst),
    .en       (rx_en),
    .lsb_first(cfg_lsb_first),
    .go       (go),
    .samp_ev  (samp_ev),
    .rxd      (lvl[CH_RXD]),
    .data     (rx_data),
    .valid    (rx_valid)
  );
endmodule

// File: rtl/codec_shifter_chk.sv
module codec_shifter_chk (
  input logic clk,
  input logic rst,
  input logic tx_en,
  input logic txd_out,
  input logic rx_valid,
  input logic tx_underrun,
  input logic tx_valid,
  input logic tx_ready
);
  AST_TXD_LOW_DISABLED: assert property (@(posedge clk) disable iff (rst)
    !tx_en |=> !txd_out); // R4
  AST_RX_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid); // R7
  AST_UNDERRUN_PULSE: assert property (@(posedge clk) disable iff (rst)
    tx_underrun |=> !tx_underrun); // R6
  AST_UNDERRUN_LINE_LOW: assert property (@(posedge clk) disable iff (rst)
    tx_underrun |-> !txd_out); // R6
  AST_UNDERRUN_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    tx_underrun |-> $past(tx_en)); // R6
  AST_HOLD_FULL_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && tx_ready) |=> !tx_ready); // R8
endmodule

bind codec_shifter codec_shifter_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .tx_en      (tx_en),
  .txd_out    (txd_out),
  .rx_valid   (rx_valid),
  .tx_underrun(tx_underrun),
  .tx_valid   (tx_valid),
  .tx_ready   (tx_ready)
);

// File: tb/codec_shifter_bench.sv
module codec_shifter_bench;
  localparam int W = 16;
  localparam int HALF = 8;
  localparam int SLOTS = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_clk_pol = 1'b0, cfg_lsb_first = 1'b0, cfg_sync_pol = 1'b0;
  logic tx_en = 1'b1, rx_en = 1'b1;
  logic bclk_in = 1'b0, fsync_in = 1'b1;
  logic [W-1:0] tx_data = '0;
  logic tx_valid = 1'b0;
  logic tx_ready, txd_out, rx_valid, tx_underrun;
  logic [W-1:0] rx_data;
  logic rxd_in;

  int n_checks = 0, n_fail = 0, ur_cnt = 0;
  logic [W-1:0] pend_q[$];
  logic [W-1:0] rx_q[$];

  always #5 clk = ~clk;
  assign rxd_in = txd_out;

  codec_shifter #(.WORD_W(W)) u_codec_shifter (
    .clk(clk), .rst(rst), .cfg_clk_pol(cfg_clk_pol), .cfg_lsb_first(cfg_lsb_first),
    .cfg_sync_pol(cfg_sync_pol), .tx_en(tx_en), .rx_en(rx_en), .bclk_in(bclk_in),
    .fsync_in(fsync_in), .rxd_in(rxd_in), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .txd_out(txd_out), .rx_data(rx_data), .rx_valid(rx_valid),
    .tx_underrun(tx_underrun)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // monitor: pops expected receive words as the design delivers them
  always @(negedge clk) begin
    if (!rst && rx_valid) begin
      if (rx_q.size() == 0) check(1'b0, "R7", "unexpected rx_valid", 32'(rx_data), 32'h0);
      else begin
        logic [W-1:0] e;
        e = rx_q.pop_front();
        check(rx_data == e, "R2/R3", "received word", 32'(rx_data), 32'(e));
      end
    end
    if (!rst && tx_underrun) ur_cnt++;
  end

  task automatic apply_cfg(input logic pol, input logic lsb, input logic spol);
    @(negedge clk);
    rst = 1'b1; cfg_clk_pol = pol; cfg_lsb_first = lsb; cfg_sync_pol = spol;
    fsync_in = ~spol; bclk_in = 1'b0; tx_valid = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  // driver: offers a word and records it as expected
  task automatic send_word(input logic [W-1:0] w);
    int guard = 0;
    @(negedge clk);
    while (!tx_ready && guard < 1000) begin @(negedge clk); guard++; end
    tx_data = w; tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    check(tx_ready == 1'b0, "R8", "tx_ready after accept", 32'(tx_ready), 32'h0);
    pend_q.push_back(w);
  endtask

  task automatic run_frame();
    logic [W-1:0] exp = '0, got = '0;
    bit exp_under = 1'b0;
    int ur0 = ur_cnt;
    if (tx_en) begin
      if (pend_q.size() > 0) exp = pend_q.pop_front();
      else exp_under = 1'b1;
    end
    if (rx_en) rx_q.push_back(exp);
    for (int s = 0; s < SLOTS; s++) begin
      for (int ph = 0; ph < 2; ph++) begin
        for (int c = 0; c < HALF; c++) begin
          @(negedge clk);
          if (c == 0) bclk_in = ph[0];
          if (ph == 0 && c == 4 && s == 0) fsync_in = cfg_sync_pol;
          if (ph == 0 && c == 4 && s == 1) fsync_in = ~cfg_sync_pol;
          if (s >= 1 && s <= W && ph == int'(cfg_clk_pol) && c == 2) begin
            if (cfg_lsb_first) got[s-1] = txd_out;
            else               got[W-s] = txd_out;
          end
          if (s == W + 2 && ph == 0 && c == 2)
            check(txd_out == 1'b0, "R4", "txd idle after word", 32'(txd_out), 32'h0);
        end
      end
    end
    check(got == exp, "R1/R3", "transmitted word", 32'(got), 32'(exp));
    check((ur_cnt - ur0) == int'(exp_under), "R6", "underrun pulses",
          32'(ur_cnt - ur0), 32'(exp_under));
    check(rx_q.size() == 0, "R7", "pending rx words", 32'(rx_q.size()), 32'h0);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL R9 watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    // R9 reset state
    apply_cfg(1'b0, 1'b0, 1'b0);
    check(txd_out == 1'b0, "R9", "reset txd", 32'(txd_out), 32'h0);
    check(rx_valid == 1'b0, "R9", "reset rx_valid", 32'(rx_valid), 32'h0);
    check(tx_ready == 1'b1, "R9", "reset tx_ready", 32'(tx_ready), 32'h1);
    check(tx_underrun == 1'b0, "R9", "reset underrun", 32'(tx_underrun), 32'h0);
    // R1 R2 R3 R5: rising launch, MSB first, active-low sync
    send_word(16'hA5C3); run_frame();
    // R3 LSB first
    apply_cfg(1'b0, 1'b1, 1'b0);
    send_word(16'h1234); run_frame();
    // R1 R2 R5: falling launch, active-high sync
    apply_cfg(1'b1, 1'b0, 1'b1);
    send_word(16'h8001); run_frame();
    apply_cfg(1'b1, 1'b1, 1'b1);
    send_word(16'h7FFE); run_frame();
    // R6 underrun
    run_frame();
    // R4 R8 transmitter disabled keeps the word
    tx_en = 1'b0;
    send_word(16'hC0DE); run_frame();
    check(tx_ready == 1'b0, "R8", "word kept while disabled", 32'(tx_ready), 32'h0);
    tx_en = 1'b1;
    run_frame();
    check(tx_ready == 1'b1, "R8", "hold empty after send", 32'(tx_ready), 32'h1);
    // R7 receiver disabled
    rx_en = 1'b0;
    send_word(16'h5A5A); run_frame();
    rx_en = 1'b1;
    apply_cfg(1'b0, 1'b0, 1'b1);
    send_word(16'hFFFF); run_frame();
    finish_run();
  end
endmodule